// File: doc/BRIEF.md
# Preloadable Reciprocal Period Counter

This block measures an asynchronous periodic input by counting it in two domains at once. It counts whole rising-edge cycles of the input, and in parallel it counts ticks of the local reference clock. When the number of whole input cycles reaches a value that software has preloaded, the block captures the tick count. The result covers a whole number of input periods, so the relative resolution depends on the gate time and not on the input frequency. A modest reference clock is therefore enough.

Consecutive gates share their boundary edge. The edge that closes one gate opens the next, and the tick on which that edge is seen belongs to the new gate. No tick and no input cycle is lost between readings, so downstream logic can sum captures to gain more precision. Conversion to frequency and any averaging are done outside the block.

The block has two states. `GATE_ARM` is entered at reset, and in it the block waits for the first synchronised rising edge. The transition *start* moves it to `GATE_RUN` on that edge. `GATE_RUN` counts ticks and edges. The transition *close* stays in `GATE_RUN`: on the edge that completes the preloaded number of cycles, it captures the counts and restarts both counters. Only reset returns the block to `GATE_ARM`.

Top module: `recip_gate_counter`

## Requirements
- R1: While `rst` is high and after its release, `cap_valid`, `cap_ticks`, `cap_cycles` and `cap_ovf` are all zero until the first capture.
- R2: `sig_in` passes through a two-flop synchroniser, and only its rising edges are counted. While the input stays at a constant level, no capture occurs.
- R3: The first gate after reset opens on the first rising edge. Each gate spans exactly N whole input cycles, where N is the active preload. For a steady period of P reference ticks, the capture gives `cap_cycles` = N and `cap_ticks` = N*P.
- R4: Gates share their boundary edge, so no tick is dropped. For consecutive captures without overflow, `cap_ticks` equals the number of reference clock cycles between the two `cap_valid` strobes.
- R5: A value written with `cfg_we` takes effect at the next gate boundary. The gate already in progress closes after the old N cycles and reports the old N.
- R6: A preload of 0 is treated as 1, so every rising edge closes a gate.
- R7: If the tick count would pass 2^TICK_W-1 before the gate closes, it saturates at that value and the capture reports `cap_ovf` = 1. The next gate that does not overflow reports `cap_ovf` = 0.
- R8: `cap_valid` is high for exactly one clock per capture. `cap_ticks`, `cap_cycles` and `cap_ovf` hold their values between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; every count is in its ticks |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Asynchronous periodic input under measurement |
| cfg_we | input | 1 | Write strobe for the cycle preload |
| cfg_cycles | input | CYC_W | Number of whole input cycles per gate (0 acts as 1) |
| cap_valid | output | 1 | One-clock strobe marking a new capture |
| cap_ticks | output | TICK_W | Reference ticks spanned by the last gate (saturating) |
| cap_cycles | output | CYC_W | Whole input cycles in the last gate |
| cap_ovf | output | 1 | Tick count saturated during the last gate |

## Verification
The checker assumes that each input level lasts at least one reference clock, so two synchronised rising edges are never closer than two ticks. Under that assumption the strobe never repeats on back-to-back cycles, and a non-saturated capture holds at least two ticks per cycle. The bench generates `sig_in` on falling clock edges. Its high and low phases are each a whole number of clocks, one or more long, and the shortest period used is three ticks, which keeps the input inside that assumption. Preload writes arrive on falling edges as one-cycle strobes.

// File: rtl/recip_pkg.sv
package recip_pkg;
    typedef enum logic {
        GATE_ARM,
        GATE_RUN
    } gate_state_e;
endpackage

// File: rtl/recip_edge_sync.sv
module recip_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_in,
    output logic rise_pulse
);
    localparam int TOP = STAGES;

    logic [TOP:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[TOP-1:0], raw_in};
        end
    end

    assign rise_pulse = pipe_q[TOP-1] & ~pipe_q[TOP];
endmodule

// File: rtl/recip_tick_ctr.sv
module recip_tick_ctr #(
    parameter int TICK_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              run,
    output logic [TICK_W-1:0] ticks,
    output logic              sat
);
    localparam logic [TICK_W-1:0] TICK_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            ticks <= '0;
            sat   <= 1'b0;
        end else if (restart) begin
            ticks <= {{(TICK_W-1){1'b0}}, 1'b1};
            sat   <= 1'b0;
        end else if (run) begin
            if (ticks == TICK_MAX) begin
                sat <= 1'b1;
            end else begin
                ticks <= ticks + 1'b1;
            end
        end
    end
endmodule

// File: rtl/recip_gate_fsm.sv
module recip_gate_fsm
    import recip_pkg::*;
#(
    parameter int TICK_W     = 20,
    parameter int CYC_W      = 8,
    parameter int DEF_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise,
    input  logic              cfg_we,
    input  logic [CYC_W-1:0]  cfg_cycles,
    input  logic [TICK_W-1:0] ticks,
    input  logic              sat,
    output logic              restart,
    output logic              run,
    output logic              cap_valid,
    output logic [TICK_W-1:0] cap_ticks,
    output logic [CYC_W-1:0]  cap_cycles,
    output logic              cap_ovf
);
    localparam logic [CYC_W-1:0] DEF_N = CYC_W'(DEF_CYCLES);
    localparam logic [CYC_W-1:0] ONE_N = {{(CYC_W-1){1'b0}}, 1'b1};

    gate_state_e state_q, state_d;
    logic [CYC_W-1:0] pend_q, active_q, edge_cnt_q;
    logic [CYC_W-1:0] next_n;
    logic close_gate, start_gate;

    assign next_n     = (pend_q == '0) ? ONE_N : pend_q;
    assign start_gate = (state_q == GATE_ARM) && rise;
    assign close_gate = (state_q == GATE_RUN) && rise && (edge_cnt_q == active_q - ONE_N);
    assign restart    = start_gate || close_gate;
    assign run        = (state_q == GATE_RUN);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_ARM: if (rise) state_d = GATE_RUN;
            GATE_RUN: state_d = GATE_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= GATE_ARM;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q     <= DEF_N;
            active_q   <= (DEF_N == '0) ? ONE_N : DEF_N;
            edge_cnt_q <= '0;
            cap_valid  <= 1'b0;
            cap_ticks  <= '0;
            cap_cycles <= '0;
            cap_ovf    <= 1'b0;
        end else begin
            cap_valid <= 1'b0;
            if (cfg_we) pend_q <= cfg_cycles;
            if (restart) begin
                edge_cnt_q <= '0;
                active_q   <= next_n;
            end else if (run && rise) begin
                edge_cnt_q <= edge_cnt_q + 1'b1;
            end
            if (close_gate) begin
                cap_valid  <= 1'b1;
                cap_ticks  <= ticks;
                cap_cycles <= active_q;
                cap_ovf    <= sat;
            end
        end
    end
endmodule

// File: rtl/recip_gate_counter.sv
module recip_gate_counter #(
    parameter int TICK_W      = 20,
    parameter int CYC_W       = 8,
    parameter int DEF_CYCLES  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sig_in,
    input  logic              cfg_we,
    input  logic [CYC_W-1:0]  cfg_cycles,
    output logic              cap_valid,
    output logic [TICK_W-1:0] cap_ticks,
    output logic [CYC_W-1:0]  cap_cycles,
    output logic              cap_ovf
);
    logic              rise;
    logic              restart;
    logic              run;
    logic [TICK_W-1:0] ticks;
    logic              sat;

    recip_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .raw_in(sig_in), .rise_pulse(rise)
    );

    recip_tick_ctr #(.TICK_W(TICK_W)) tick_i (
        .clk(clk), .rst(rst), .restart(restart), .run(run),
        .ticks(ticks), .sat(sat)
    );

    recip_gate_fsm #(.TICK_W(TICK_W), .CYC_W(CYC_W), .DEF_CYCLES(DEF_CYCLES)) fsm_i (
        .clk(clk), .rst(rst), .rise(rise), .cfg_we(cfg_we), .cfg_cycles(cfg_cycles),
        .ticks(ticks), .sat(sat), .restart(restart), .run(run),
        .cap_valid(cap_valid), .cap_ticks(cap_ticks), .cap_cycles(cap_cycles),
        .cap_ovf(cap_ovf)
    );
endmodule

// File: rtl/recip_gate_checker.sv
module recip_gate_checker #(
    parameter int TICK_W = 20,
    parameter int CYC_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cap_valid,
    input logic [TICK_W-1:0] cap_ticks,
    input logic [CYC_W-1:0]  cap_cycles,
    input logic              cap_ovf
);
    localparam logic [TICK_W-1:0] TICK_MAX = '1;

    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (rst)
        cap_valid |=> !cap_valid);

    assert_capture_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !cap_valid |-> ($stable(cap_ticks) && $stable(cap_cycles) && $stable(cap_ovf)));

    assert_cycles_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
        cap_valid |-> (cap_cycles != '0));

    assert_ticks_floor_R3: assert property (@(posedge clk) disable iff (rst)
        (cap_valid && !cap_ovf) |-> ({1'b0, cap_ticks} >= ({1'b0, cap_ticks} - {1'b0, cap_ticks} + 2 * (TICK_W+1)'(cap_cycles))));

    assert_saturated_R7: assert property (@(posedge clk) disable iff (rst)
        (cap_valid && cap_ovf) |-> (cap_ticks == TICK_MAX));
endmodule

bind recip_gate_counter recip_gate_checker #(.TICK_W(TICK_W), .CYC_W(CYC_W)) chk_i (
    .clk(clk), .rst(rst), .cap_valid(cap_valid), .cap_ticks(cap_ticks),
    .cap_cycles(cap_cycles), .cap_ovf(cap_ovf)
);

// File: tb/recip_gate_counter_tb.sv
module recip_gate_counter_tb_top;
    localparam int TICK_W = 10;
    localparam int CYC_W  = 8;
    localparam int NVEC   = 6;
    localparam int VEC [NVEC][2] = '{'{8, 4}, '{10, 1}, '{6, 7}, '{20, 3}, '{3, 5}, '{14, 2}};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sig_in = 1'b0;
    logic cfg_we = 1'b0;
    logic [CYC_W-1:0] cfg_cycles = '0;
    logic cap_valid;
    logic [TICK_W-1:0] cap_ticks;
    logic [CYC_W-1:0] cap_cycles;
    logic cap_ovf;

    int checks = 0;
    int errors = 0;
    int per = 8;
    logic gen_en = 1'b0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    recip_gate_counter #(.TICK_W(TICK_W), .CYC_W(CYC_W), .DEF_CYCLES(4)) dut_i (
        .clk(clk), .rst(rst), .sig_in(sig_in), .cfg_we(cfg_we), .cfg_cycles(cfg_cycles),
        .cap_valid(cap_valid), .cap_ticks(cap_ticks), .cap_cycles(cap_cycles), .cap_ovf(cap_ovf)
    );

    always begin
        if (!gen_en) begin
            sig_in = 1'b0;
            @(negedge clk);
        end else begin
            int p;
            p = per;
            sig_in = 1'b1;
            repeat (p / 2) @(negedge clk);
            sig_in = 1'b0;
            repeat (p - p / 2) @(negedge clk);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cap(output int gap);
        logic [TICK_W-1:0] t0;
        logic [CYC_W-1:0] c0;
        logic o0;
        bit moved;
        t0 = cap_ticks; c0 = cap_cycles; o0 = cap_ovf; moved = 0;
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
            if (!cap_valid && (cap_ticks != t0 || cap_cycles != c0 || cap_ovf != o0)) moved = 1;
        end while (!cap_valid && gap < 6000);
        check(!moved, "R8 hold", int'(cap_ticks), int'(t0));
        if (!cap_valid) check(0, "capture timeout", gap, 0);
    endtask

    task automatic write_cfg(input int n);
        cfg_we = 1'b1;
        cfg_cycles = CYC_W'(n);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        #600000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int g;
        int seen;
        repeat (4) @(negedge clk);
        check(cap_valid == 0 && cap_ticks == 0 && cap_cycles == 0 && cap_ovf == 0,
              "R1 reset", int'(cap_ticks), 0);
        rst = 1'b0;
        // R2: static input gives no capture
        seen = 0;
        repeat (120) begin
            @(negedge clk);
            if (cap_valid) seen++;
        end
        check(seen == 0, "R2 static input", seen, 0);
        check(cap_ticks == 0 && cap_cycles == 0, "R1 after release", int'(cap_cycles), 0);
        // R3: first gate opens on first edge, default N=4, P=8
        per = 8;
        gen_en = 1'b1;
        wait_cap(g);
        check(cap_cycles == 4, "R3 first gate cycles", int'(cap_cycles), 4);
        check(cap_ticks == 32, "R3 first gate ticks", int'(cap_ticks), 32);
        // R5: new preload waits for next boundary
        write_cfg(2);
        wait_cap(g);
        check(cap_cycles == 4, "R5 old preload kept", int'(cap_cycles), 4);
        check(cap_ticks == 32, "R5 old gate ticks", int'(cap_ticks), 32);
        wait_cap(g);
        check(cap_cycles == 2, "R5 new preload", int'(cap_cycles), 2);
        check(cap_ticks == 16, "R5 new gate ticks", int'(cap_ticks), 16);
        // vector table: R3 and R4
        for (int i = 0; i < NVEC; i++) begin
            per = VEC[i][0];
            write_cfg(VEC[i][1]);
            wait_cap(g);
            wait_cap(g);
            wait_cap(g);
            check(cap_cycles == CYC_W'(VEC[i][1]), "R3 cycles", int'(cap_cycles), VEC[i][1]);
            check(cap_ticks == TICK_W'(VEC[i][0] * VEC[i][1]), "R3 ticks",
                  int'(cap_ticks), VEC[i][0] * VEC[i][1]);
            check(cap_ovf == 0, "R3 no overflow", int'(cap_ovf), 0);
            wait_cap(g);
            check(int'(cap_ticks) == g, "R4 strobe spacing", int'(cap_ticks), g);
        end
        // R6: preload of zero acts as one
        per = 12;
        write_cfg(0);
        wait_cap(g); wait_cap(g); wait_cap(g);
        check(cap_cycles == 1, "R6 zero preload cycles", int'(cap_cycles), 1);
        check(cap_ticks == 12, "R6 zero preload ticks", int'(cap_ticks), 12);
        wait_cap(g);
        check(int'(cap_ticks) == g, "R4 spacing N=1", int'(cap_ticks), g);
        // R7: overflow 8*200 > 1023
        per = 8;
        write_cfg(200);
        wait_cap(g); wait_cap(g); wait_cap(g);
        check(cap_ovf == 1, "R7 overflow flag", int'(cap_ovf), 1);
        check(cap_ticks == 1023, "R7 saturation", int'(cap_ticks), 1023);
        write_cfg(4);
        wait_cap(g); wait_cap(g);
        check(cap_ovf == 0, "R7 flag cleared", int'(cap_ovf), 0);
        check(cap_ticks == 32, "R7 recovery ticks", int'(cap_ticks), 32);
        // R1: reset during activity clears captures
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(cap_valid == 0 && cap_ticks == 0 && cap_cycles == 0 && cap_ovf == 0,
              "R1 mid-run reset", int'(cap_ticks), 0);
        gen_en = 1'b0;
        repeat (20) @(negedge clk);
        rst = 1'b0;
        gen_en = 1'b1;
        wait_cap(g);
        check(cap_cycles == 4 && cap_ticks == 32, "R3 default after reset", int'(cap_ticks), 32);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule